// File: doc/BRIEF.md
# Arbitrating Two-Wire Bus Bit Master

This block is the bit-level engine of a master on a shared two-wire open-drain bus. The two lines are a clock and a data line. The block never drives either line high. It only asserts a pull-down enable, so its outputs combine with those of every other device as a wired-AND. A byte-level controller above it issues one command at a time:

- emit a start condition;
- send one bit;
- read one bit, which also serves as the acknowledge slot;
- emit a stop condition.

The block answers each completed command with a one-cycle done strobe.

The block stays correct when other masters and stretching slaves share the bus. After it releases the clock, it waits until the sensed clock line is really high, and only then counts its high phase. If the clock is pulled low early, it ends its high phase. Every data 1 it sends is compared with the sensed line. When another master wins, the block lets go of both lines and raises a lost flag. It then ignores commands until it sees a stop condition on the bus.

States:

| State | Role |
| --- | --- |
| IDLE | Holds the lines as the last command left them and waits for a command. |
| LOW | Pulls the clock low for the low phase and presents the data level. |
| RISE | Releases the clock and waits for it to be sensed high. |
| HIGH1 | Times the first high phase, samples data and checks arbitration. |
| HIGH2 | Second high phase, used by start and stop, after the data edge. |
| FIN | Strobes done and fixes the lines the command leaves behind. |
| LOST | Both lines released until a bus stop is sensed. |

Transitions:

- IDLE→LOW on a command.
- LOW→RISE after the low count.
- RISE→HIGH1 when the clock is sensed high.
- HIGH1→HIGH2 for start and stop.
- HIGH1→FIN for data bits, at the end of the count or when the clock is sensed low early.
- HIGH1→LOST on arbitration loss.
- HIGH2→FIN.
- FIN→IDLE.
- LOST→IDLE on a sensed stop.

Top module: `twm_master`

## Requirements
- R1: After reset both pull-down enables are 0, and done and the lost flag are 0.
- R2: During a write or read bit, the data line changes only while the clock line is low. No start or stop edge appears on the bus during a data bit.
- R3: Command code 0 (start) produces a falling data edge while the clock line is high. The block then holds both lines pulled low.
- R4: Command code 3 (stop) produces a rising data edge while the clock line is high. The block then leaves both lines released.
- R5: Command code 1 (write) sets the data pull-down enable to the inverse of the bit value. That level is held after the bit completes.
- R6: Command code 2 (read) releases the data line. The read bit output reports the level sensed while the clock line was high.
- R7: Every bit pulls the clock low for at least LOW_CYC system clocks before releasing it.
- R8: After releasing the clock, the block does not begin its high phase while the clock line is sensed low, so a stretched clock delays completion.
- R9: The clock high phase lasts HIGH_CYC clocks counted from the sensed rise, plus the input synchronizer latency. A data bit ends early when the clock line is sensed low before that count ends.
- R10: Done is a single-cycle pulse at the end of each command.
- R11: If a written 1 is sensed as 0 while the clock line is high, the lost flag rises and both enables are released.
- R12: While the lost flag is set, commands are ignored. The flag clears after a stop condition is sensed on the bus.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command request, taken in IDLE |
| cmd_op | input | 2 | 0 start, 1 write, 2 read, 3 stop |
| cmd_bit | input | 1 | Bit value for write |
| scl_in | input | 1 | Sensed clock line level |
| sda_in | input | 1 | Sensed data line level |
| scl_oe | output | 1 | Clock line pull-down enable |
| sda_oe | output | 1 | Data line pull-down enable |
| done | output | 1 | Command complete strobe |
| rx_bit | output | 1 | Last bit read |
| arb_lost | output | 1 | Arbitration lost, waiting for bus stop |

## Verification
A vector table runs a transaction made of start, write 1, write 0, reads with the slave holding data low and released, stop, and a repeated start. This separates the four command encodings and the levels each leaves on the lines, and a bus monitor counts the start and stop edges each command produces. Directed cases then cover three further situations. A slave holding the clock low shows that the high phase waits for the sensed rise. An external low in mid-high shows that a bit ends early. A competing master pulling data low under a written 1 shows the loss path, the refusal of commands, and the recovery after a bus stop.

// File: rtl/twm_pkg.sv
package twm_pkg;

    typedef enum logic [1:0] {
        CMD_START = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_STOP  = 2'd3
    } twm_cmd_e;

    // pull-down levels of the data line in each phase of a command
    typedef struct packed {
        logic low;
        logic hi1;
        logic hi2;
    } twm_lvl_t;

    function automatic twm_lvl_t twm_levels(twm_cmd_e op, logic b);
        twm_lvl_t l;
        unique case (op)
            CMD_START: l = '{low: 1'b0, hi1: 1'b0, hi2: 1'b1};
            CMD_WRITE: l = '{low: ~b,   hi1: ~b,   hi2: ~b};
            CMD_READ:  l = '{low: 1'b0, hi1: 1'b0, hi2: 1'b0};
            default:   l = '{low: 1'b1, hi1: 1'b1, hi2: 1'b0};
        endcase
        return l;
    endfunction

endpackage

// File: rtl/twm_sync.sv
module twm_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '1;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/twm_bus_watch.sv
module twm_bus_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic stop_seen
);
    logic scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // data rising while the clock stays high
    assign stop_seen = scl_d & scl_s & ~sda_d & sda_s;
endmodule

// File: rtl/twm_master.sv
module twm_master #(
    parameter int LOW_CYC     = 10,
    parameter int HIGH_CYC    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    input  logic       cmd_bit,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       done,
    output logic       rx_bit,
    output logic       arb_lost
);
    import twm_pkg::*;

    localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef enum logic [2:0] {
        ST_IDLE, ST_LOW, ST_RISE, ST_HIGH1, ST_HIGH2, ST_FIN, ST_LOST
    } st_e;

    st_e       st, st_nx;
    logic [CW-1:0] cnt;
    twm_cmd_e  op;
    logic      bit_q, scl_hold, sda_hold, rx_q;
    logic      scl_s, sda_s, stop_seen;
    twm_lvl_t  lvl;
    logic      two_phase, arb_hit;

    twm_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q({scl_s, sda_s})
    );

    twm_bus_watch u_watch (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s), .stop_seen(stop_seen)
    );

    assign lvl       = twm_levels(op, bit_q);
    assign two_phase = (op == CMD_START) || (op == CMD_STOP);
    assign arb_hit   = (op == CMD_WRITE) && bit_q && scl_s && !sda_s;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (cmd_valid) st_nx = ST_LOW;
            ST_LOW:   if (cnt == CW'(LOW_CYC - 1)) st_nx = ST_RISE;
            ST_RISE:  if (scl_s) st_nx = ST_HIGH1;
            ST_HIGH1: begin
                if (arb_hit)                         st_nx = ST_LOST;
                else if (!two_phase && !scl_s)       st_nx = ST_FIN;
                else if (cnt == CW'(HIGH_CYC - 1))   st_nx = two_phase ? ST_HIGH2 : ST_FIN;
            end
            ST_HIGH2: if (cnt == CW'(HIGH_CYC - 1)) st_nx = ST_FIN;
            ST_FIN:   st_nx = ST_IDLE;
            ST_LOST:  if (stop_seen) st_nx = ST_IDLE;
            default:  st_nx = ST_IDLE;
        endcase
    end

    // state register and the registers it owns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            op       <= CMD_START;
            bit_q    <= 1'b0;
            scl_hold <= 1'b0;
            sda_hold <= 1'b0;
            rx_q     <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= (st_nx != st) ? '0 : cnt + 1'b1;
            if (st == ST_IDLE && cmd_valid) begin
                op    <= twm_cmd_e'(cmd_op);
                bit_q <= cmd_bit;
            end
            if (st == ST_HIGH1 && op == CMD_READ && scl_s) rx_q <= sda_s;
            if (st == ST_FIN) begin
                scl_hold <= (op != CMD_STOP);
                sda_hold <= lvl.hi2;
            end else if (st_nx == ST_LOST) begin
                scl_hold <= 1'b0;
                sda_hold <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        scl_oe   = 1'b0;
        sda_oe   = 1'b0;
        done     = 1'b0;
        arb_lost = 1'b0;
        unique case (st)
            ST_IDLE:  begin scl_oe = scl_hold; sda_oe = sda_hold; end
            ST_LOW:   begin scl_oe = 1'b1;     sda_oe = lvl.low;  end
            ST_RISE,
            ST_HIGH1: begin scl_oe = 1'b0;     sda_oe = lvl.hi1;  end
            ST_HIGH2: begin scl_oe = 1'b0;     sda_oe = lvl.hi2;  end
            ST_FIN:   begin scl_oe = (op != CMD_STOP); sda_oe = lvl.hi2; done = 1'b1; end
            ST_LOST:  arb_lost = 1'b1;
            default:  ;
        endcase
    end

    assign rx_bit = rx_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10
    AST_RISE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RISE && !scl_s) |=> (st == ST_RISE)); // R8
    AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HIGH1 && $past(st) == ST_HIGH1) |-> $stable(sda_oe)); // R2
    AST_LOSS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> $past(scl_s && !sda_s)); // R11
    AST_LOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOST && !stop_seen) |=> arb_lost); // R12
endmodule

// File: tb/twm_master_test.sv
module twm_master_test;
    localparam int LOW_CYC  = 10;
    localparam int HIGH_CYC = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic cmd_bit = 1'b0;
    logic ext_scl_low = 1'b0, ext_sda_low = 1'b0, slave_low = 1'b0;
    logic scl_oe, sda_oe, done, rx_bit, arb_lost;
    logic scl_line, sda_line;

    int compared = 0, mismatched = 0, cyc = 0;
    int starts = 0, stops = 0, hi_run = 0, last_hi = 0, lo_run = 0, last_lo = 0;
    logic p_scl = 1'b1, p_sda = 1'b1;

    always #2.5 clk = ~clk;

    assign scl_line = ~(scl_oe | ext_scl_low);
    assign sda_line = ~(sda_oe | ext_sda_low | slave_low);

    twm_master #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bit(cmd_bit), .scl_in(scl_line), .sda_in(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .done(done), .rx_bit(rx_bit),
        .arb_lost(arb_lost)
    );

    // bus monitor
    always @(negedge clk) begin
        if (p_scl && scl_line && p_sda && !sda_line) starts++;
        if (p_scl && scl_line && !p_sda && sda_line) stops++;
        if (scl_line) hi_run++;
        else if (hi_run > 0) begin last_hi = hi_run; hi_run = 0; end
        if (scl_oe) lo_run++;
        else if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    task automatic report;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: run hung, act=%0d exp<150000", cyc);
            report();
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // issue a command and wait for done or loss; returns the cycles waited
    task automatic issue(input logic [1:0] op, input logic b, output int waited);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bit = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        waited = 0;
        while (!done && !arb_lost && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    // [5:4] op, [3] bit, [2] slave pulls data, [1] expected rx, [0] expected sda_oe after
    localparam logic [5:0] VEC [10] = '{
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b1, 1'b0, 1'b0, 1'b0},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
        {2'd2, 1'b0, 1'b0, 1'b1, 1'b0},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd1, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
        {2'd3, 1'b0, 1'b0, 1'b0, 1'b0}
    };

    initial begin
        int w, s0, p0, gone;
        logic [1:0] op;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R1 enables", {scl_oe, sda_oe}, 0);
        chk(done == 0 && arb_lost == 0, "R1 flags", {done, arb_lost}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        for (int i = 0; i < 10; i++) begin
            op = VEC[i][5:4];
            slave_low = VEC[i][2];
            s0 = starts; p0 = stops;
            issue(op, VEC[i][3], w);
            chk(done == 1, "R10 done seen", done, 1);
            chk(arb_lost == 0, "R11 no loss", arb_lost, 0);
            @(negedge clk);
            slave_low = 1'b0;
            chk(done == 0, "R10 single pulse", done, 0);
            chk(scl_oe == (op != 2'd3), (op == 2'd3) ? "R4 scl after" : "R3 scl after",
                scl_oe, (op != 2'd3));
            chk(sda_oe == VEC[i][0], (op == 2'd1) ? "R5 sda level" : "R3 sda after",
                sda_oe, VEC[i][0]);
            chk(starts - s0 == (op == 2'd0), (op == 2'd0) ? "R3 start edge" : "R2 no start",
                starts - s0, (op == 2'd0));
            chk(stops - p0 == (op == 2'd3), (op == 2'd3) ? "R4 stop edge" : "R2 no stop",
                stops - p0, (op == 2'd3));
            if (op == 2'd2) chk(rx_bit == VEC[i][1], "R6 read value", rx_bit, VEC[i][1]);
            if (op == 2'd1 || op == 2'd2) begin
                chk(last_hi >= HIGH_CYC && last_hi <= HIGH_CYC + 4, "R9 high length",
                    last_hi, HIGH_CYC);
                chk(last_lo >= LOW_CYC, "R7 low length", last_lo, LOW_CYC);
            end
        end

        // R8: stretched clock
        issue(2'd0, 1'b0, w);
        @(negedge clk);
        ext_scl_low = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd1; cmd_bit = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (scl_oe) @(negedge clk);
        gone = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done || scl_oe) gone = 1;
        end
        chk(gone == 0, "R8 waits while stretched", gone, 0);
        ext_scl_low = 1'b0;
        w = 0;
        while (!done && w < 200) begin @(negedge clk); w++; end
        chk(done == 1, "R8 completes after release", done, 1);
        @(negedge clk);
        chk(last_hi >= HIGH_CYC && last_hi <= HIGH_CYC + 4, "R8 high after stretch",
            last_hi, HIGH_CYC);

        // R9: external low ends high phase early
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd2; cmd_bit = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!scl_line) @(negedge clk);
        repeat (3) @(negedge clk);
        ext_scl_low = 1'b1;
        w = 0;
        while (!done && w < 200) begin @(negedge clk); w++; end
        chk(done == 1 && w < HIGH_CYC, "R9 early end", w, HIGH_CYC);
        @(negedge clk);
        chk(last_hi < HIGH_CYC, "R9 shortened high", last_hi, HIGH_CYC);
        chk(rx_bit == 1, "R6 read released", rx_bit, 1);
        repeat (3) @(negedge clk);
        ext_scl_low = 1'b0;

        // R11: another master wins a written 1
        ext_sda_low = 1'b1;
        issue(2'd1, 1'b1, w);
        chk(arb_lost == 1, "R11 lost flag", arb_lost, 1);
        chk(scl_oe == 0 && sda_oe == 0, "R11 lines released", {scl_oe, sda_oe}, 0);

        // R12: ignored commands, then recovery on bus stop
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd0;
        @(negedge clk);
        cmd_valid = 1'b0;
        gone = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (done || scl_oe || sda_oe || !arb_lost) gone = 1;
        end
        chk(gone == 0, "R12 commands ignored", gone, 0);
        ext_sda_low = 1'b0;
        repeat (8) @(negedge clk);
        chk(arb_lost == 0, "R12 cleared by stop", arb_lost, 0);
        s0 = starts;
        issue(2'd0, 1'b0, w);
        chk(done == 1 && starts - s0 == 1, "R12 accepts after recovery", starts - s0, 1);
        issue(2'd3, 1'b0, w);
        @(negedge clk);
        chk(scl_oe == 0 && sda_oe == 0, "R4 released at end", {scl_oe, sda_oe}, 0);

        report();
    end
endmodule